// File: doc/BRIEF.md
# Floating-Point Normalize, Round and Pack Stage

This block is the back end shared by floating-point operations that produce an unpacked result: a 32-bit two's-complement fraction, left-justified with its binary point just below the sign bit, and a signed exponent held in two's complement. It brings the fraction to normal form, rounds it to 24 significant bits with a constant that depends on the sign, corrects the fraction when rounding disturbs its form, and classifies the exponent. It then returns a packed 32-bit word as two 16-bit halves, together with an overflow flag.

The packed word keeps the 24-bit fraction in the upper bits. Below the fraction sit a 7-bit exponent field and, in bit 0, a flag that marks a negative exponent. Results that are too small become a clean zero. Results that are too large saturate to the largest positive pattern. Both cases raise the overflow flag.

Both edges of the block are valid/ready streams. An operand moves in on a cycle where `in_valid` and `in_ready` are both high. Its result is presented one cycle later, in a single output register. That register holds its value while `out_ready` is low, and `in_ready` is low during that time. When `out_ready` is high, the block can take one operand on every cycle.

Top module: `flt_norm_round_pack`

## Requirements
- R1: An operand accepted on a clock edge (`in_valid` and `in_ready` both high) appears on `out_valid` after that edge. While `out_valid` is high and `out_ready` is low, the outputs keep their values, `in_ready` is low, and offered input is ignored. With `out_ready` held high, one operand is accepted on every cycle.
- R2: A nonzero fraction is shifted left, and the exponent is lowered by one for each shift, until fraction bit 30 differs from bit 31. In every nonzero, non-overflow result, `out_hi[15]` differs from `out_hi[14]`.
- R3: A zero fraction gives `out_hi` = 0, `out_lo` = 0 and `out_ovf` = 0, whatever the input exponent.
- R4: After normalization, 0x80 is added to a fraction with bit 31 = 0, and 0x7F is added to a fraction with bit 31 = 1. Bits 7..0 of the sum are then cleared.
- R5: If rounding changes bit 31, the fraction is shifted right logically by one bit (a 0 enters bit 31) and the exponent is raised by one. For example, 0x7FFFFFC0 with exponent 3 packs to 0x40000008.
- R6: If rounding leaves bit 31 unchanged, the result is normalized again. For example, 0xBFFFFFC0 with exponent 5 packs to 0x80000008.
- R7: A final exponent below -128 gives the all-zero word with `out_ovf` = 1.
- R8: A final exponent above 127 gives `out_hi` = 0x7FFF, `out_lo` = 0xFFFE and `out_ovf` = 1.
- R9: For an in-range result, `out_hi` holds fraction bits 31..16. `out_lo[15:8]` holds fraction bits 15..8. `out_lo[7:1]` holds the low 7 bits of the exponent in two's complement. `out_lo[0]` is 1 exactly when the exponent is negative. The exponent limits -128 and 127 are both in range.
- R10: `out_ovf` is 0 for every in-range result and for zero, and is valid in the same cycle as `out_valid`.
- R11: While `rst` is high and on the cycle after it, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | An unpacked operand is offered |
| in_ready | output | 1 | The block can accept an operand this cycle |
| in_frac | input | 32 | Two's-complement fraction, left-justified |
| in_exp | input | 10 | Two's-complement exponent |
| out_valid | output | 1 | A packed result is presented |
| out_ready | input | 1 | The consumer takes the result this cycle |
| out_hi | output | 16 | Upper half of the packed word |
| out_lo | output | 16 | Lower half of the packed word |
| out_ovf | output | 1 | The exponent went out of range (underflow or overflow) |

## Verification
The hardest paths to reach are the two that follow rounding: a carry into the sign bit, and a negative fraction that rounds into a non-normal form. Random fractions almost never have their low bits positioned to trigger either case. Directed operands with all ones, or with a one followed by all zeros, just above the guard byte drive both paths. Other directed operands place the final exponent on each side of -128 and 127, either directly or through normalization shifts and the rounding increment. Random traffic with random output stalls covers the rest.

// File: rtl/flt_nrp_pkg.sv
package flt_nrp_pkg;
  localparam int unsigned NRP_FRAC_W = 32;
  localparam int unsigned NRP_EXF_W  = 7;
  localparam int unsigned NRP_EXP_W  = 10;

  typedef enum logic [1:0] {
    CLS_NORMAL = 2'd0,
    CLS_ZERO   = 2'd1,
    CLS_UNDER  = 2'd2,
    CLS_OVER   = 2'd3
  } nrp_class_e;
endpackage

// File: rtl/flt_nrp_norm.sv
module flt_nrp_norm #(
  parameter int unsigned FRAC_W = 32,
  parameter int unsigned IW     = 16
) (
  input  logic [FRAC_W-1:0]    frac_i,
  input  logic signed [IW-1:0] exp_i,
  output logic [FRAC_W-1:0]    frac_o,
  output logic signed [IW-1:0] exp_o
);
  localparam int unsigned CW = $clog2(FRAC_W);

  logic [FRAC_W-2:0] diff;
  logic [CW-1:0]     shamt;
  logic              found;

  // Bits below the sign that differ from the sign mark the stopping point.
  assign diff = frac_i[FRAC_W-2:0] ^ {(FRAC_W-1){frac_i[FRAC_W-1]}};

  always_comb begin
    shamt = CW'(FRAC_W-1);
    found = 1'b0;
    for (int i = FRAC_W-2; i >= 0; i--) begin
      if (!found && diff[i]) begin
        shamt = CW'(FRAC_W-2-i);
        found = 1'b1;
      end
    end
  end

  always_comb begin
    if (frac_i == '0) begin
      frac_o = '0;
      exp_o  = '0;
    end else begin
      frac_o = frac_i << shamt;
      exp_o  = exp_i - IW'(shamt);
    end
  end
endmodule

// File: rtl/flt_nrp_round.sv
module flt_nrp_round #(
  parameter int unsigned FRAC_W = 32,
  parameter int unsigned GUARD  = 8,
  parameter int unsigned IW     = 16
) (
  input  logic [FRAC_W-1:0]    frac_i,
  input  logic signed [IW-1:0] exp_i,
  output logic [FRAC_W-1:0]    frac_o,
  output logic signed [IW-1:0] exp_o
);
  localparam logic [FRAC_W-1:0] RND_POS = FRAC_W'(1) << (GUARD-1);
  localparam logic [FRAC_W-1:0] RND_NEG = RND_POS - FRAC_W'(1);

  logic [FRAC_W-1:0]    sum;
  logic [FRAC_W-1:0]    kept;
  logic                 flip;
  logic [FRAC_W-1:0]    rn_frac;
  logic signed [IW-1:0] rn_exp;

  assign sum  = frac_i + (frac_i[FRAC_W-1] ? RND_NEG : RND_POS);
  assign kept = {sum[FRAC_W-1:GUARD], {GUARD{1'b0}}};
  assign flip = kept[FRAC_W-1] ^ frac_i[FRAC_W-1];

  flt_nrp_norm #(.FRAC_W(FRAC_W), .IW(IW)) u_renorm (
    .frac_i (kept),
    .exp_i  (exp_i),
    .frac_o (rn_frac),
    .exp_o  (rn_exp)
  );

  always_comb begin
    if (flip) begin
      frac_o = {1'b0, kept[FRAC_W-1:1]};
      exp_o  = exp_i + IW'(1);
    end else begin
      frac_o = rn_frac;
      exp_o  = rn_exp;
    end
  end
endmodule

// File: rtl/flt_nrp_pack.sv
module flt_nrp_pack
  import flt_nrp_pkg::*;
#(
  parameter int unsigned FRAC_W = 32,
  parameter int unsigned EXF_W  = 7,
  parameter int unsigned IW     = 16
) (
  input  logic [FRAC_W-1:0]    frac_i,
  input  logic signed [IW-1:0] exp_i,
  output logic [FRAC_W-1:0]    word_o,
  output logic                 ovf_o
);
  localparam int unsigned GUARD = EXF_W + 1;
  localparam logic signed [IW-1:0] LIM_HI = IW'((1 << EXF_W) - 1);
  localparam logic signed [IW-1:0] LIM_LO = -LIM_HI - IW'(1);
  localparam logic [FRAC_W-1:0] SAT = {1'b0, {(FRAC_W-2){1'b1}}, 1'b0};

  nrp_class_e cls;

  always_comb begin
    if (frac_i == '0)         cls = CLS_ZERO;
    else if (exp_i < LIM_LO)  cls = CLS_UNDER;
    else if (exp_i > LIM_HI)  cls = CLS_OVER;
    else                      cls = CLS_NORMAL;
  end

  always_comb begin
    unique case (cls)
      CLS_ZERO:  begin word_o = '0;  ovf_o = 1'b0; end
      CLS_UNDER: begin word_o = '0;  ovf_o = 1'b1; end
      CLS_OVER:  begin word_o = SAT; ovf_o = 1'b1; end
      default: begin
        word_o = {frac_i[FRAC_W-1:GUARD], exp_i[EXF_W-1:0], exp_i[IW-1]};
        ovf_o  = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/flt_norm_round_pack.sv
module flt_norm_round_pack
  import flt_nrp_pkg::*;
#(
  parameter int unsigned FRAC_W = NRP_FRAC_W,
  parameter int unsigned EXF_W  = NRP_EXF_W,
  parameter int unsigned EXP_W  = NRP_EXP_W,
  localparam int unsigned HALF_W = FRAC_W / 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [FRAC_W-1:0] in_frac,
  input  logic [EXP_W-1:0]  in_exp,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [HALF_W-1:0] out_hi,
  output logic [HALF_W-1:0] out_lo,
  output logic              out_ovf
);
  localparam int unsigned IW    = EXP_W + 6;
  localparam int unsigned GUARD = EXF_W + 1;

  logic signed [IW-1:0] exp_ext;
  logic [FRAC_W-1:0]    n_frac, r_frac, word;
  logic signed [IW-1:0] n_exp, r_exp;
  logic                 ovf;
  logic                 take;

  assign exp_ext = IW'($signed(in_exp));

  flt_nrp_norm #(.FRAC_W(FRAC_W), .IW(IW)) u_norm (
    .frac_i (in_frac),
    .exp_i  (exp_ext),
    .frac_o (n_frac),
    .exp_o  (n_exp)
  );

  flt_nrp_round #(.FRAC_W(FRAC_W), .GUARD(GUARD), .IW(IW)) u_round (
    .frac_i (n_frac),
    .exp_i  (n_exp),
    .frac_o (r_frac),
    .exp_o  (r_exp)
  );

  flt_nrp_pack #(.FRAC_W(FRAC_W), .EXF_W(EXF_W), .IW(IW)) u_pack (
    .frac_i (r_frac),
    .exp_i  (r_exp),
    .word_o (word),
    .ovf_o  (ovf)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_hi    <= '0;
      out_lo    <= '0;
      out_ovf   <= 1'b0;
    end else begin
      if (take) begin
        out_valid <= 1'b1;
        out_hi    <= word[FRAC_W-1:HALF_W];
        out_lo    <= word[HALF_W-1:0];
        out_ovf   <= ovf;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/flt_nrp_checker.sv
module flt_nrp_checker #(
  parameter int unsigned HALF_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [HALF_W-1:0] out_hi,
  input logic [HALF_W-1:0] out_lo,
  input logic              out_ovf
);
  localparam logic [HALF_W-1:0] SAT_HI = {1'b0, {(HALF_W-1){1'b1}}};
  localparam logic [HALF_W-1:0] SAT_LO = {{(HALF_W-1){1'b1}}, 1'b0};

  // R1: an accepted operand is presented on the next cycle
  assert_accept_R1: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid);

  // R1: a stalled result holds still
  assert_hold_R1: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_hi) && $stable(out_lo) && $stable(out_ovf));

  // R1: no acceptance while stalled
  assert_stall_R1: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready);

  // R2: nonzero in-range results are normalized
  assert_norm_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ovf && (out_hi != '0) |-> out_hi[HALF_W-1] != out_hi[HALF_W-2]);

  // R3: a zero upper half means a clean zero word
  assert_zero_R3: assert property (@(posedge clk) disable iff (rst)
    out_valid && (out_hi == '0) |-> out_lo == '0);

  // R8: a raised flag with a nonzero word is the saturation pattern
  assert_sat_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ovf && (out_hi != '0) |-> (out_hi == SAT_HI) && (out_lo == SAT_LO));

  // R11: reset empties the output register
  assert_reset_R11: assert property (@(posedge clk)
    rst |=> !out_valid);
endmodule

bind flt_norm_round_pack flt_nrp_checker #(.HALF_W(HALF_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_hi    (out_hi),
  .out_lo    (out_lo),
  .out_ovf   (out_ovf)
);

// File: tb/flt_norm_round_pack_tb.sv
module flt_norm_round_pack_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_frac = '0;
  logic [9:0]  in_exp = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [15:0] out_hi, out_lo;
  logic        out_ovf;

  int n_chk = 0;
  int n_bad = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  flt_norm_round_pack u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_frac(in_frac), .in_exp(in_exp), .out_valid(out_valid),
    .out_ready(out_ready), .out_hi(out_hi), .out_lo(out_lo), .out_ovf(out_ovf)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Model built from the requirements: {ovf, 32-bit word}
  function automatic logic [32:0] model(input logic [31:0] f, input int e);
    logic [31:0] r;
    int x = e;
    if (f == 0) return 33'h0;
    while (f[30] == f[31]) begin f = f << 1; x--; end
    r = (f + (f[31] ? 32'h7F : 32'h80)) & 32'hFFFF_FF00;
    if (r[31] != f[31]) begin r = r >> 1; x++; end
    else while (r[30] == r[31]) begin r = r << 1; x--; end
    if (x < -128) return {1'b1, 32'h0};
    if (x > 127)  return {1'b1, 32'h7FFF_FFFE};
    return {1'b0, r[31:8], x[6:0], (x < 0) ? 1'b1 : 1'b0};
  endfunction

  task automatic xact(input logic [31:0] f, input int e, input int stall, input string req);
    logic [32:0] ex = model(f, e);
    logic [32:0] got;
    @(negedge clk);
    in_valid = 1'b1; in_frac = f; in_exp = e[9:0]; out_ready = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid === 1'b1, "R1 result presented", 64'(out_valid), 64'd1);
    got = {out_ovf, out_hi, out_lo};
    check(got === ex, req, 64'(got), 64'(ex));
    if (!ex[32] && ex[31:0] != 0)
      check(out_hi[15] != out_hi[14], "R2 normalized form", 64'(out_hi), 64'(ex[31:16]));
    for (int i = 0; i < stall; i++) begin
      in_valid = 1'b1; in_frac = ~f; in_exp = ~e[9:0];
      @(negedge clk);
      check(in_ready === 1'b0, "R1 not ready while stalled", 64'(in_ready), 64'd0);
      check({out_ovf, out_hi, out_lo} === ex, "R1 held under stall", 64'({out_ovf, out_hi, out_lo}), 64'(ex));
    end
    in_valid = 1'b0; out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    check(out_valid === 1'b0, "R1 drained", 64'(out_valid), 64'd0);
  endtask

  initial begin : watchdog
    while (!finished) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        n_bad++; n_chk++;
        $display("FAIL watchdog actual=%0d expected=<150000", cycles);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
      end
    end
  end

  initial begin : stim
    logic [31:0] bf [5];
    int          be [5];
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R11 valid low in reset", 64'(out_valid), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid === 1'b0, "R11 valid low after reset", 64'(out_valid), 64'd0);
    check(in_ready === 1'b1, "R1 ready when empty", 64'(in_ready), 64'd1);

    xact(32'h0000_0000, 77, 1, "R3 zero with exponent");
    xact(32'h4000_0180, 0, 0, "R4 positive rounding");
    xact(32'h8000_0180, 2, 0, "R4 negative rounding");
    xact(32'h7FFF_FFC0, 3, 2, "R5 carry into sign");
    xact(32'hBFFF_FFC0, 5, 0, "R6 renormalize after round");
    xact(32'h0000_0001, 0, 0, "R2 deep shift");
    xact(32'hFFFF_FFFF, 0, 0, "R2 all ones");
    xact(32'h4000_0000, -128, 0, "R9 low limit in range");
    xact(32'h4000_0000, 127, 0, "R9 high limit in range");
    xact(32'h4000_0000, -129, 0, "R7 underflow");
    xact(32'h0000_0001, -100, 0, "R7 underflow via shift");
    xact(32'h4000_0000, 128, 3, "R8 overflow");
    xact(32'h7FFF_FFC0, 127, 0, "R8 overflow via rounding");
    xact(32'h9234_5600, -5, 0, "R10 in-range flag clear");

    // R1 throughput: one operand per cycle with the consumer always ready
    for (int i = 0; i < 5; i++) begin
      bf[i] = $urandom; be[i] = int'($urandom_range(0, 60)) - 30;
    end
    out_ready = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (i > 0) begin
        check({out_ovf, out_hi, out_lo} === model(bf[i-1], be[i-1]), "R1 back-to-back result",
              64'({out_ovf, out_hi, out_lo}), 64'(model(bf[i-1], be[i-1])));
        check(in_ready === 1'b1, "R1 ready in burst", 64'(in_ready), 64'd1);
      end
      in_valid = 1'b1; in_frac = bf[i]; in_exp = be[i][9:0];
    end
    @(negedge clk);
    in_valid = 1'b0;
    check({out_ovf, out_hi, out_lo} === model(bf[4], be[4]), "R1 back-to-back result",
          64'({out_ovf, out_hi, out_lo}), 64'(model(bf[4], be[4])));
    @(negedge clk);
    out_ready = 1'b0;

    // Random operands; some shifted to be unnormalized, exponents near the limits
    for (int n = 0; n < 400; n++) begin
      logic [31:0] f = $urandom;
      int e = int'($urandom_range(0, 400)) - 200;
      if ($urandom_range(0, 1) == 1) f = $signed(f) >>> $urandom_range(0, 31);
      if ($urandom_range(0, 15) == 0) f = 32'h0;
      xact(f, e, int'($urandom_range(0, 2)), "R9 random pack");
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule